// File: doc/BRIEF.md
# Condition-Flag Data Processing ALU

This block is the execute stage of a 32-bit integer datapath. Each cycle it takes a first operand, a second operand that an external shifter has already prepared, that shifter's carry-out, the current N, Z, C, V condition flags, a 4-bit operation code and a set-flags request. One clock edge later it presents the computed value, a destination write enable and the next condition flags. It covers sixteen register-only operations: six add and subtract forms (including reverse subtract and the carry-chained variants), four bitwise forms (including bit-clear), two moves that use only the second operand, and four comparisons.

Comparisons always update the flags and never write a destination. The other operations update the flags only when set-flags is high; otherwise the flags pass through unchanged. For arithmetic the carry and overflow flags come from the adder, and carry means "no borrow" in subtraction. For bitwise and move forms the carry takes the shifter's carry-out and overflow keeps its old value.

Top module: `dp_alu`

## Requirements
- R1: While `rstN` is low and at the first edge after it, `result`, `writeEn` and `flagsOut` are all zero.
- R2: Opcode 4 adds (A+B), opcode 5 adds with carry (A+B+C), and each writes its 32-bit sum with `writeEn`=1.
- R3: Opcode 2 gives A-B, opcode 3 gives B-A, opcode 6 gives A-B-(1-C) and opcode 7 gives B-A-(1-C), each with `writeEn`=1. The carry flag produced is 1 exactly when no borrow occurs, so for opcode 2 C=1 when A>=B unsigned.
- R4: Opcode 0 gives A AND B, opcode 1 gives A XOR B, opcode 12 gives A OR B and opcode 14 gives A AND NOT B, each with `writeEn`=1.
- R5: Opcode 13 gives B and opcode 15 gives NOT B with `writeEn`=1. `opA` has no effect on either.
- R6: Opcodes 8 (A AND B), 9 (A XOR B), 10 (A-B) and 11 (A+B) drive `writeEn`=0, present the computed value on `result`, and update the flags whatever the value of `setFlags`.
- R7: For opcodes other than 8 to 11 with `setFlags`=0, `flagsOut` equals the `flagsIn` sampled with the operation.
- R8: When flags update, N is result bit 31 and Z is 1 exactly when the result is zero. For the arithmetic and compare-arithmetic opcodes, C is the unsigned carry (or no-borrow) and V is set on signed overflow.
- R9: When flags update for the bitwise, test and move opcodes (0, 1, 8, 9, 12, 13, 14, 15), C equals `shiftCarry` and V equals `flagsIn[0]`.
- R10: Flags are packed with N at bit 3, Z at bit 2, C at bit 1 and V at bit 0 on both `flagsIn` and `flagsOut`. The outputs for the inputs sampled at a rising edge appear after that edge and remain stable until the next one.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rstN | input | 1 | Synchronous reset, active low |
| opA | input | 32 | First operand |
| opB | input | 32 | Second operand, already shifted |
| shiftCarry | input | 1 | Carry-out of the operand shifter |
| flagsIn | input | 4 | Current flags {N,Z,C,V} |
| opcode | input | 4 | Operation select |
| setFlags | input | 1 | Request a flag update for non-compare operations |
| result | output | 32 | Computed value |
| writeEn | output | 1 | Destination register write enable |
| flagsOut | output | 4 | Next flags {N,Z,C,V} |

## Verification
Several hundred random operand pairs run over all sixteen opcodes with random flags, shifter carry and set-flags. This separates the operand roles (reverse against forward subtract, and bit-clear against AND) and the carry-in source of the chained forms. Directed vectors reach the boundaries that random values seldom hit: signed overflow at 0x7FFFFFFF+1, borrow at 0-1, an exact zero from equal operands, and carry-chained forms with the carry both set and clear. Further directed vectors apply moves with a hostile `opA`, set-flags low with nonzero incoming flags, and compares with set-flags low. These show the no-effect and flags-only rules at the ports. One vector also checks that the outputs hold until the edge.

// File: rtl/dp_alu_pkg.sv
package dp_alu_pkg;

  localparam int FLAG_W = 4;
  localparam int FLAG_N = 3;
  localparam int FLAG_Z = 2;
  localparam int FLAG_C = 1;
  localparam int FLAG_V = 0;

  typedef enum logic [3:0] {
    OP_AND   = 4'd0,
    OP_XOR   = 4'd1,
    OP_SUB   = 4'd2,
    OP_RSUB  = 4'd3,
    OP_ADD   = 4'd4,
    OP_ADDC  = 4'd5,
    OP_SUBC  = 4'd6,
    OP_RSUBC = 4'd7,
    OP_TEST  = 4'd8,
    OP_TESTX = 4'd9,
    OP_CMP   = 4'd10,
    OP_CMPN  = 4'd11,
    OP_OR    = 4'd12,
    OP_MOVE  = 4'd13,
    OP_CLEAR = 4'd14,
    OP_MOVEN = 4'd15
  } aluOp_e;

  typedef enum logic [1:0] {
    CIN_ZERO = 2'd0,
    CIN_ONE  = 2'd1,
    CIN_FLAG = 2'd2
  } carrySel_e;

  typedef enum logic [1:0] {
    LG_AND  = 2'd0,
    LG_XOR  = 2'd1,
    LG_OR   = 2'd2,
    LG_PASS = 2'd3
  } logicSel_e;

  typedef struct packed {
    logic      useAdder;
    logic      invA;
    logic      invB;
    carrySel_e cinSel;
    logicSel_e logicSel;
    logic      invLogicB;
    logic      writeDest;
    logic      updateFlags;
  } aluStrobes_t;

endpackage

// File: rtl/dp_alu_ctrl.sv
module dp_alu_ctrl
  import dp_alu_pkg::*;
(
  input  logic [3:0]  opcode,
  input  logic        setFlags,
  output aluStrobes_t strobes
);

  logic isCompare;

  always_comb begin
    strobes           = '0;
    strobes.cinSel    = CIN_ZERO;
    strobes.logicSel  = LG_AND;
    isCompare         = 1'b0;
    case (aluOp_e'(opcode))
      OP_AND:   strobes.logicSel = LG_AND;
      OP_XOR:   strobes.logicSel = LG_XOR;
      OP_OR:    strobes.logicSel = LG_OR;
      OP_CLEAR: begin
        strobes.logicSel  = LG_AND;
        strobes.invLogicB = 1'b1;
      end
      OP_MOVE:  strobes.logicSel = LG_PASS;
      OP_MOVEN: begin
        strobes.logicSel  = LG_PASS;
        strobes.invLogicB = 1'b1;
      end
      OP_ADD: begin
        strobes.useAdder = 1'b1;
      end
      OP_ADDC: begin
        strobes.useAdder = 1'b1;
        strobes.cinSel   = CIN_FLAG;
      end
      OP_SUB: begin
        strobes.useAdder = 1'b1;
        strobes.invB     = 1'b1;
        strobes.cinSel   = CIN_ONE;
      end
      OP_SUBC: begin
        strobes.useAdder = 1'b1;
        strobes.invB     = 1'b1;
        strobes.cinSel   = CIN_FLAG;
      end
      OP_RSUB: begin
        strobes.useAdder = 1'b1;
        strobes.invA     = 1'b1;
        strobes.cinSel   = CIN_ONE;
      end
      OP_RSUBC: begin
        strobes.useAdder = 1'b1;
        strobes.invA     = 1'b1;
        strobes.cinSel   = CIN_FLAG;
      end
      OP_TEST: begin
        strobes.logicSel = LG_AND;
        isCompare        = 1'b1;
      end
      OP_TESTX: begin
        strobes.logicSel = LG_XOR;
        isCompare        = 1'b1;
      end
      OP_CMP: begin
        strobes.useAdder = 1'b1;
        strobes.invB     = 1'b1;
        strobes.cinSel   = CIN_ONE;
        isCompare        = 1'b1;
      end
      OP_CMPN: begin
        strobes.useAdder = 1'b1;
        isCompare        = 1'b1;
      end
      default: strobes.logicSel = LG_AND;
    endcase
    strobes.writeDest   = !isCompare;
    strobes.updateFlags = isCompare || setFlags;
  end

endmodule

// File: rtl/dp_alu_datapath.sv
module dp_alu_datapath
  import dp_alu_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [DATA_W-1:0] opA,
  input  logic [DATA_W-1:0] opB,
  input  logic              shiftCarry,
  input  logic [FLAG_W-1:0] flagsIn,
  input  aluStrobes_t       strobes,
  output logic [DATA_W-1:0] result,
  output logic              writeEn,
  output logic [FLAG_W-1:0] flagsOut
);

  localparam int MSB = DATA_W - 1;

  logic [DATA_W-1:0] addA, addB, logicB, logicRes, nextRes;
  logic [DATA_W:0]   sum;
  logic              carryIn, overflow;
  logic [FLAG_W-1:0] nextFlags;

  // Adder operand conditioning: inversion gives subtract and reverse subtract
  assign addA = strobes.invA ? ~opA : opA;
  assign addB = strobes.invB ? ~opB : opB;

  always_comb begin
    case (strobes.cinSel)
      CIN_ONE:  carryIn = 1'b1;
      CIN_FLAG: carryIn = flagsIn[FLAG_C];
      default:  carryIn = 1'b0;
    endcase
  end

  assign sum = {1'b0, addA} + {1'b0, addB} + {{DATA_W{1'b0}}, carryIn};
  assign overflow = (addA[MSB] == addB[MSB]) && (sum[MSB] != addA[MSB]);

  // Bitwise unit
  assign logicB = strobes.invLogicB ? ~opB : opB;

  always_comb begin
    case (strobes.logicSel)
      LG_XOR:  logicRes = opA ^ logicB;
      LG_OR:   logicRes = opA | logicB;
      LG_PASS: logicRes = logicB;
      default: logicRes = opA & logicB;
    endcase
  end

  assign nextRes = strobes.useAdder ? sum[MSB:0] : logicRes;

  always_comb begin
    nextFlags = flagsIn;
    if (strobes.updateFlags) begin
      nextFlags[FLAG_N] = nextRes[MSB];
      nextFlags[FLAG_Z] = (nextRes == '0);
      nextFlags[FLAG_C] = strobes.useAdder ? sum[DATA_W] : shiftCarry;
      nextFlags[FLAG_V] = strobes.useAdder ? overflow : flagsIn[FLAG_V];
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      result   <= '0;
      writeEn  <= 1'b0;
      flagsOut <= '0;
    end else begin
      result   <= nextRes;
      writeEn  <= strobes.writeDest;
      flagsOut <= nextFlags;
    end
  end

endmodule

// File: rtl/dp_alu.sv
module dp_alu
  import dp_alu_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [DATA_W-1:0] opA,
  input  logic [DATA_W-1:0] opB,
  input  logic              shiftCarry,
  input  logic [3:0]        flagsIn,
  input  logic [3:0]        opcode,
  input  logic              setFlags,
  output logic [DATA_W-1:0] result,
  output logic              writeEn,
  output logic [3:0]        flagsOut
);

  aluStrobes_t strobes;

  dp_alu_ctrl u_ctrl (
    .opcode   (opcode),
    .setFlags (setFlags),
    .strobes  (strobes)
  );

  dp_alu_datapath #(.DATA_W(DATA_W)) u_dpath (
    .clk        (clk),
    .rstN       (rstN),
    .opA        (opA),
    .opB        (opB),
    .shiftCarry (shiftCarry),
    .flagsIn    (flagsIn),
    .strobes    (strobes),
    .result     (result),
    .writeEn    (writeEn),
    .flagsOut   (flagsOut)
  );

endmodule

// File: rtl/dp_alu_checker.sv
module dp_alu_checker #(
  parameter int DATA_W = 32
) (
  input logic              clk,
  input logic              rstN,
  input logic [DATA_W-1:0] opA,
  input logic [DATA_W-1:0] opB,
  input logic              shiftCarry,
  input logic [3:0]        flagsIn,
  input logic [3:0]        opcode,
  input logic              setFlags,
  input logic [DATA_W-1:0] result,
  input logic              writeEn,
  input logic [3:0]        flagsOut
);

  logic isCmp, isBitwise, upd;
  assign isCmp     = (opcode[3:2] == 2'b10);
  assign isBitwise = (opcode == 4'd0) || (opcode == 4'd1) || (opcode == 4'd8) ||
                     (opcode == 4'd9) || (opcode >= 4'd12);
  assign upd       = isCmp || setFlags;

  // R1: reset clears outputs
  assert_reset_clear_R1: assert property (@(posedge clk)
    !rstN |=> (result == '0) && !writeEn && (flagsOut == 4'd0));

  // R6: comparisons never write a destination
  assert_cmp_no_write_R6: assert property (@(posedge clk) disable iff (!rstN)
    isCmp |=> !writeEn);

  // R6: all other opcodes write
  assert_noncmp_write_R6: assert property (@(posedge clk) disable iff (!rstN)
    !isCmp |=> writeEn);

  // R7: flags pass through when no update is requested
  assert_flags_hold_R7: assert property (@(posedge clk) disable iff (!rstN)
    !upd |=> flagsOut == $past(flagsIn));

  // R8: N and Z follow the result whenever flags update
  assert_nz_track_R8: assert property (@(posedge clk) disable iff (!rstN)
    upd |=> (flagsOut[3] == result[DATA_W-1]) && (flagsOut[2] == (result == '0)));

  // R9: bitwise and move forms take C from the shifter and keep V
  assert_logic_cv_R9: assert property (@(posedge clk) disable iff (!rstN)
    (upd && isBitwise) |=> (flagsOut[1] == $past(shiftCarry)) &&
                           (flagsOut[0] == $past(flagsIn[0])));

  // R5: move returns the second operand unchanged
  assert_move_passes_b_R5: assert property (@(posedge clk) disable iff (!rstN)
    (opcode == 4'd13) |=> result == $past(opB));

endmodule

bind dp_alu dp_alu_checker #(.DATA_W(DATA_W)) u_chk (.*);

// File: tb/dp_alu_tb.sv
`timescale 1ns/1ps
module dp_alu_tb;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [31:0] opA = '0, opB = '0;
  logic        shiftCarry = 1'b0;
  logic [3:0]  flagsIn = '0;
  logic [3:0]  opcode = '0;
  logic        setFlags = 1'b0;
  logic [31:0] result;
  logic        writeEn;
  logic [3:0]  flagsOut;

  int checks = 0;
  int fails  = 0;
  int cycles = 0;

  always #4 clk = ~clk;

  dp_alu u_dut (
    .clk(clk), .rstN(rstN), .opA(opA), .opB(opB), .shiftCarry(shiftCarry),
    .flagsIn(flagsIn), .opcode(opcode), .setFlags(setFlags),
    .result(result), .writeEn(writeEn), .flagsOut(flagsOut)
  );

  always @(posedge clk) begin
    cycles <= cycles + 1;
    if (cycles > 100000) begin
      fails = fails + 1;
      checks = checks + 1;
      $display("FAIL watchdog: run did not finish (actual %0d cycles, expected < 100000)", cycles);
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
    checks = checks + 1;
    if (act !== exp) begin
      fails = fails + 1;
      $display("FAIL %s: actual %h expected %h (op %0d a %h b %h f %b s %b)",
               tag, act, exp, opcode, opA, opB, flagsIn, setFlags);
    end
  endtask

  // Reference model: {result, writeEn, flags}
  function automatic logic [36:0] model(logic [3:0] op, logic [31:0] a, logic [31:0] b,
                                        logic sc, logic [3:0] f, logic sf);
    longint sa, sb, ss;
    longint ua, ub, us;
    logic [31:0] r;
    logic c, v, arith, cmp;
    sa = longint'($signed(a));
    sb = longint'($signed(b));
    ua = longint'({32'd0, a});
    ub = longint'({32'd0, b});
    arith = 1'b0; ss = 0; us = 0; r = '0;
    case (op)
      4'd0, 4'd8:   r = a & b;
      4'd1, 4'd9:   r = a ^ b;
      4'd12:        r = a | b;
      4'd13:        r = b;
      4'd14:        r = a & ~b;
      4'd15:        r = ~b;
      4'd4, 4'd11:  begin arith = 1'b1; ss = sa + sb; us = ua + ub; end
      4'd5:         begin arith = 1'b1; ss = sa + sb + longint'(f[1]); us = ua + ub + longint'(f[1]); end
      4'd2, 4'd10:  begin arith = 1'b1; ss = sa - sb; us = ua - ub; end
      4'd6:         begin arith = 1'b1; ss = sa - sb - longint'(!f[1]); us = ua - ub - longint'(!f[1]); end
      4'd3:         begin arith = 1'b1; ss = sb - sa; us = ub - ua; end
      default:      begin arith = 1'b1; ss = sb - sa - longint'(!f[1]); us = ub - ua - longint'(!f[1]); end
    endcase
    if (arith) begin
      r = ss[31:0];
      v = (ss > 64'sd2147483647) || (ss < -64'sd2147483648);
      if (op == 4'd4 || op == 4'd5 || op == 4'd11) c = (us >= 64'sd4294967296);
      else c = (us >= 0);
    end else begin
      c = sc;
      v = f[0];
    end
    cmp = (op[3:2] == 2'b10);
    if (cmp || sf) return {r, !cmp, r[31], (r == 32'd0), c, v};
    else           return {r, !cmp, f};
  endfunction

  function automatic string opTag(logic [3:0] op);
    case (op)
      4'd4, 4'd5:                return "R2";
      4'd2, 4'd3, 4'd6, 4'd7:    return "R3";
      4'd0, 4'd1, 4'd12, 4'd14:  return "R4";
      4'd13, 4'd15:              return "R5";
      default:                   return "R6";
    endcase
  endfunction

  function automatic string flagTag(logic [3:0] op, logic sf);
    if (!(op[3:2] == 2'b10) && !sf) return "R7";
    if (op inside {4'd2, 4'd3, 4'd4, 4'd5, 4'd6, 4'd7, 4'd10, 4'd11}) return "R8";
    return "R9";
  endfunction

  task automatic apply(logic [3:0] op, logic [31:0] a, logic [31:0] b,
                       logic sc, logic [3:0] f, logic sf);
    logic [36:0] exp;
    @(negedge clk);
    opcode = op; opA = a; opB = b; shiftCarry = sc; flagsIn = f; setFlags = sf;
    exp = model(op, a, b, sc, f, sf);
    @(negedge clk);
    check(opTag(op), result, exp[36:5]);
    check(op[3:2] == 2'b10 ? "R6" : opTag(op), {31'd0, writeEn}, {31'd0, exp[4]});
    check(flagTag(op, sf), {28'd0, flagsOut}, {28'd0, exp[3:0]});
  endtask

  initial begin
    logic [36:0] prev;
    void'($urandom(32'h1234_5eed));
    // R1 reset state
    repeat (3) @(negedge clk);
    check("R1", result, 32'd0);
    check("R1", {31'd0, writeEn}, 32'd0);
    check("R1", {28'd0, flagsOut}, 32'd0);
    rstN = 1'b1;

    // R8 signed overflow on add
    apply(4'd4, 32'h7FFF_FFFF, 32'h1, 1'b0, 4'b0000, 1'b1);
    check("R8", {28'd0, flagsOut}, {28'd0, 4'b1001});
    // R3 equal subtract: zero, no borrow
    apply(4'd2, 32'h55, 32'h55, 1'b0, 4'b0000, 1'b1);
    check("R3", {28'd0, flagsOut}, {28'd0, 4'b0110});
    // R3 0-1 borrows
    apply(4'd2, 32'h0, 32'h1, 1'b1, 4'b0000, 1'b1);
    check("R3", {28'd0, flagsOut}, {28'd0, 4'b1000});
    // R3 reverse subtract and carry-chained forms, both carry values
    apply(4'd3, 32'd10, 32'd3, 1'b0, 4'b0000, 1'b1);
    apply(4'd6, 32'd10, 32'd3, 1'b0, 4'b0000, 1'b1);
    apply(4'd6, 32'd10, 32'd3, 1'b0, 4'b0010, 1'b1);
    apply(4'd7, 32'd3, 32'd10, 1'b0, 4'b0010, 1'b0);
    // R2 add with carry, both carry values, wrap to zero
    apply(4'd5, 32'hFFFF_FFFF, 32'h0, 1'b0, 4'b0010, 1'b1);
    check("R2", result, 32'd0);
    apply(4'd5, 32'hFFFF_FFFF, 32'h0, 1'b0, 4'b0000, 1'b1);
    // R5 moves ignore a hostile first operand
    apply(4'd13, 32'hDEAD_BEEF, 32'h0000_1234, 1'b1, 4'b0001, 1'b1);
    check("R5", result, 32'h0000_1234);
    apply(4'd15, 32'hFFFF_FFFF, 32'h0F0F_0F0F, 1'b0, 4'b0000, 1'b0);
    check("R5", result, 32'hF0F0_F0F0);
    // R4 bit-clear
    apply(4'd14, 32'hFF00_FF00, 32'hF0F0_F0F0, 1'b0, 4'b0000, 1'b0);
    check("R4", result, 32'h0F00_0F00);
    // R6 compare with set-flags low still updates, no write
    apply(4'd10, 32'd5, 32'd5, 1'b0, 4'b1001, 1'b0);
    check("R6", {28'd0, flagsOut}, {28'd0, 4'b0110});
    apply(4'd8, 32'hF0, 32'h0F, 1'b0, 4'b0001, 1'b0);
    check("R9", {28'd0, flagsOut}, {28'd0, 4'b0101});
    // R7 no update keeps nonzero incoming flags
    apply(4'd4, 32'hFFFF_FFFF, 32'h1, 1'b1, 4'b1010, 1'b0);
    check("R7", {28'd0, flagsOut}, {28'd0, 4'b1010});

    // R10 outputs hold until the edge
    prev = {result, writeEn, flagsOut};
    @(negedge clk);
    opcode = 4'd0; opA = 32'h1; opB = 32'h2; shiftCarry = 1'b1; flagsIn = 4'b0101; setFlags = 1'b1;
    #1;
    check("R10", {result[30:0], writeEn}, {prev[35:5], prev[4]});
    check("R10", {28'd0, flagsOut}, {28'd0, prev[3:0]});
    @(negedge clk);
    check("R10", {28'd0, flagsOut}, {28'd0, 4'b0111});

    // Random mix over all opcodes
    for (int i = 0; i < 400; i++) begin
      logic [31:0] ra, rb;
      ra = $urandom;
      rb = $urandom;
      if (i % 7 == 0) rb = ra;
      if (i % 11 == 0) ra = 32'h8000_0000;
      apply(4'($urandom_range(0, 15)), ra, rb, 1'($urandom), 4'($urandom), 1'($urandom));
    end

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

endmodule